// File: doc/BRIEF.md
# Weight-Stationary Double-Buffered Systolic Array

The block is a grid of `ROWS` by `COLS` multiply-accumulate cells. Each cell keeps one weight in place for as long as a tile is in use. Activation vectors enter from the left edge and move one cell to the right per clock. Partial sums start at zero on the top edge, move one cell down per clock, and leave the bottom edge as finished dot products. Each output column `c` yields `sum over r of x[r] * W[r][c]`. Input skew registers stagger the rows and output deskew registers line the columns up again, so a whole input vector goes in on one cycle and a whole result vector comes out on one cycle.

Each cell holds two weight registers. The active register feeds the multiplier. The shadow register belongs to a per-column shift chain that carries a new weight tile in from the top edge while the current tile is still computing. A swap moves every shadow register into its active register on the same clock edge. A counter records how many shift steps have gone into the shadow tile. A swap request that comes before the tile is complete is held until the counter reaches `ROWS`.

Top module: `ws_systolic_array`

## Requirements
- R1: After reset, `y_valid_o` is 0, `y_o` is 0, and every active and shadow weight is 0, so vectors sent before the first swap produce zero results.
- R2: Each cycle with `wt_shift_i` high moves every column's shadow weights down one row, and the column's `wt_top_i` word (column `c` at bits `c*WW +: WW`) enters row 0. Over a run of `ROWS` shifts, the word given at the k-th shift (k = 1..ROWS) ends in row `ROWS-k`. Shifting alone never changes the results.
- R3: More than `ROWS` shifts without a swap keep the chain moving, and the word in row `ROWS-1` is lost. The shift counter stops at `ROWS`.
- R4: A swap fires on a cycle where a request is present (new or held) and the counter equals `ROWS`. On that edge every cell copies its shadow weight into its active weight. The counter restarts at 0, or at 1 if a shift happens on the same cycle; that shift takes effect after the copy.
- R5: A swap request made while the counter is below `ROWS` is not lost. It is held, and it fires on the first cycle the counter equals `ROWS`.
- R6: Activations and weights are two's-complement. `y_o` column `c` (bits `c*PW +: PW`) holds the signed sum of `x[r]*W[r][c]` over all rows, where `x[r]` is `x_i[r*AW +: AW]`.
- R7: A vector sampled with `x_valid_i` high produces its result on all columns at once. `y_valid_o` rises on the `ROWS+COLS-1`-th clock edge, counting the sampling edge as the first.
- R8: For a vector sampled in cycle T, the product at row r, column c uses the weight that is active in cycle T+r+c. Vectors that are in flight when a swap happens therefore mix the two tiles in this way.
- R9: While `y_valid_o` is low, `y_o` is zero, because the activations of an invalid slot are forced to zero.
- R10: Vectors can be issued on every cycle while shifting and swapping go on at the same time, and each result still follows R6 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wt_shift_i | input | 1 | Shift the shadow weight chains one row down |
| wt_top_i | input | COLS*WW | Weight word entering row 0 of each column |
| swap_req_i | input | 1 | Request to move shadow weights into active weights |
| x_valid_i | input | 1 | Activation vector valid |
| x_i | input | ROWS*AW | Activation vector, one signed element per row |
| y_valid_o | output | 1 | Result vector valid |
| y_o | output | COLS*PW | Result vector, one signed sum per column |

## Verification
The bench starts a swap request after a single shift and then keeps shifting. A controller that dropped early requests would leave the old tile in place, and one that fired at once would expose a half-loaded tile; both show up as wrong sums. It over-shifts a tile before swapping, which catches a counter that wraps instead of stopping, and it shifts on the very cycle a swap fires, which catches a restart value off by one. Long stretches of back-to-back vectors straddle swaps, so any cell that swapped late or early, or any skew or deskew stage off by one cycle, produces column sums that mix the wrong tiles. Idle gaps check that invalid slots produce zeros rather than leftover partial sums.

// File: rtl/ws_pkg.sv
package ws_pkg;

    // State of the swap request holder
    typedef enum logic [0:0] {
        SWAP_IDLE = 1'b0,
        SWAP_HELD = 1'b1
    } swap_state_e;

endpackage

// File: rtl/ws_delay.sv
// Fixed-depth register delay line; depth 0 is a plain wire.
module ws_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    generate
        if (DEPTH == 0) begin : g_wire
            logic tie_unused;
            assign tie_unused = clk ^ rst_n;
            assign q_o = d_i;
        end else begin : g_pipe
            logic [W-1:0] pipe_d [DEPTH];
            logic [W-1:0] pipe_q [DEPTH];

            always_comb begin
                pipe_d[0] = d_i;
                for (int i = 1; i < DEPTH; i++) begin
                    pipe_d[i] = pipe_q[i-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) begin
                        pipe_q[i] <= '0;
                    end
                end else begin
                    for (int i = 0; i < DEPTH; i++) begin
                        pipe_q[i] <= pipe_d[i];
                    end
                end
            end

            assign q_o = pipe_q[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/ws_swap_ctrl.sv
// Counts preload shifts and releases a swap once a full tile is present.
module ws_swap_ctrl
    import ws_pkg::*;
#(
    parameter int ROWS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_i,
    input  logic req_i,
    output logic fire_o
);

    localparam int CW = $clog2(ROWS + 1);
    localparam logic [CW-1:0] FULL = CW'(ROWS);

    typedef struct packed {
        logic [CW-1:0] cnt;
        swap_state_e   st;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  fire;

    always_comb begin
        ctl_d = ctl_q;
        fire  = (req_i || (ctl_q.st == SWAP_HELD)) && (ctl_q.cnt == FULL);
        if (fire) begin
            ctl_d.cnt = shift_i ? CW'(1) : '0;
            ctl_d.st  = SWAP_IDLE;
        end else begin
            if (shift_i && (ctl_q.cnt != FULL)) begin
                ctl_d.cnt = ctl_q.cnt + CW'(1);
            end
            if (req_i) begin
                ctl_d.st = SWAP_HELD;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{cnt: '0, st: SWAP_IDLE};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign fire_o = fire;

    // R3: the shift counter never passes a full tile
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.cnt <= FULL);

    // R5: an early request is remembered
    a_r5_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && (ctl_q.cnt != FULL)) |=> (ctl_q.st == SWAP_HELD));

    // R4: after a swap the count restarts
    a_r4_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> (ctl_q.cnt <= CW'(1)));

endmodule

// File: rtl/ws_pe.sv
// One cell: active/shadow weight pair, activation hop, partial-sum hop.
module ws_pe #(
    parameter int AW = 8,
    parameter int WW = 8,
    parameter int PW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] a_i,
    input  logic [PW-1:0] ps_i,
    input  logic [WW-1:0] w_i,
    input  logic          shift_i,
    input  logic          swap_i,
    output logic [AW-1:0] a_o,
    output logic [PW-1:0] ps_o,
    output logic [WW-1:0] w_o
);

    localparam int MW = AW + WW;

    typedef struct packed {
        logic [AW-1:0] act;
        logic [WW-1:0] shadow;
        logic [WW-1:0] live;
        logic [PW-1:0] ps;
    } cell_t;

    cell_t cell_d, cell_q;

    logic signed [MW-1:0] prod;
    logic signed [PW-1:0] prod_x;

    assign prod   = $signed(a_i) * $signed(cell_q.live);
    assign prod_x = prod;

    always_comb begin
        cell_d     = cell_q;
        cell_d.act = a_i;
        cell_d.ps  = ps_i + prod_x;
        if (swap_i) begin
            cell_d.live = cell_q.shadow;
        end
        if (shift_i) begin
            cell_d.shadow = w_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_q <= '0;
        end else begin
            cell_q <= cell_d;
        end
    end

    assign a_o  = cell_q.act;
    assign ps_o = cell_q.ps;
    assign w_o  = cell_q.shadow;

    // R4: a swap copies the shadow weight into the live weight
    a_r4_swap_copies: assert property (@(posedge clk) disable iff (!rst_n)
        swap_i |=> (cell_q.live == $past(cell_q.shadow)));

    // R2: live weight is stationary between swaps
    a_r2_live_stationary: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_i |=> $stable(cell_q.live));

    // R2: shadow weight moves only on a shift
    a_r2_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_i |=> $stable(cell_q.shadow));

endmodule

// File: rtl/ws_systolic_array.sv
module ws_systolic_array #(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int AW   = 8,
    parameter int WW   = 8,
    parameter int PW   = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wt_shift_i,
    input  logic [COLS*WW-1:0]   wt_top_i,
    input  logic                 swap_req_i,
    input  logic                 x_valid_i,
    input  logic [ROWS*AW-1:0]   x_i,
    output logic                 y_valid_o,
    output logic [COLS*PW-1:0]   y_o
);

    localparam int LAT = ROWS + COLS - 1;

    logic              swap_fire;
    logic [ROWS*AW-1:0] x_gated;

    logic [AW-1:0] a_link  [ROWS][COLS+1];
    logic [PW-1:0] ps_link [ROWS+1][COLS];
    logic [WW-1:0] w_link  [ROWS+1][COLS];

    // invalid slots enter as zero so idle results stay zero
    always_comb begin
        x_gated = x_valid_i ? x_i : '0;
    end

    ws_swap_ctrl #(.ROWS(ROWS)) u_swap (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (wt_shift_i),
        .req_i   (swap_req_i),
        .fire_o  (swap_fire)
    );

    // input skew: row r is delayed r cycles
    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_skew
            ws_delay #(.W(AW), .DEPTH(r)) u_skew (
                .clk   (clk),
                .rst_n (rst_n),
                .d_i   (x_gated[r*AW +: AW]),
                .q_o   (a_link[r][0])
            );
        end

        for (genvar c = 0; c < COLS; c++) begin : g_top
            assign ps_link[0][c] = '0;
            assign w_link[0][c]  = wt_top_i[c*WW +: WW];
        end

        for (genvar r = 0; r < ROWS; r++) begin : g_row
            for (genvar c = 0; c < COLS; c++) begin : g_col
                ws_pe #(.AW(AW), .WW(WW), .PW(PW)) u_pe (
                    .clk     (clk),
                    .rst_n   (rst_n),
                    .a_i     (a_link[r][c]),
                    .ps_i    (ps_link[r][c]),
                    .w_i     (w_link[r][c]),
                    .shift_i (wt_shift_i),
                    .swap_i  (swap_fire),
                    .a_o     (a_link[r][c+1]),
                    .ps_o    (ps_link[r+1][c]),
                    .w_o     (w_link[r+1][c])
                );
            end
        end

        // output deskew: column c waits COLS-1-c cycles
        for (genvar c = 0; c < COLS; c++) begin : g_deskew
            ws_delay #(.W(PW), .DEPTH(COLS-1-c)) u_deskew (
                .clk   (clk),
                .rst_n (rst_n),
                .d_i   (ps_link[ROWS][c]),
                .q_o   (y_o[c*PW +: PW])
            );
        end
    endgenerate

    ws_delay #(.W(1), .DEPTH(LAT)) u_valid (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (x_valid_i),
        .q_o   (y_valid_o)
    );

    // edge outputs of the grid that lead nowhere
    logic edge_unused;
    always_comb begin
        edge_unused = 1'b0;
        for (int r = 0; r < ROWS; r++) begin
            edge_unused = edge_unused ^ (^a_link[r][COLS]);
        end
        for (int c = 0; c < COLS; c++) begin
            edge_unused = edge_unused ^ (^w_link[ROWS][c]);
        end
    end

    // R9: idle result slots carry zero
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !y_valid_o |-> (y_o == '0));

    // R1: outputs leave reset cleared
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !y_valid_o);

endmodule

// File: tb/tb_ws_systolic_array.sv
module tb_ws_systolic_array;

    localparam int ROWS = 4;
    localparam int COLS = 4;
    localparam int AW   = 8;
    localparam int WW   = 8;
    localparam int PW   = 20;
    localparam int LAT  = ROWS + COLS - 1;
    localparam int H    = 64;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wt_shift = 1'b0;
    logic [COLS*WW-1:0] wt_top = '0;
    logic               swap_req = 1'b0;
    logic               x_valid = 1'b0;
    logic [ROWS*AW-1:0] x_bus = '0;
    logic               y_valid;
    logic [COLS*PW-1:0] y_bus;

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R1";
    bit    chk_on = 0;
    bit    done = 0;

    ws_systolic_array #(
        .ROWS(ROWS), .COLS(COLS), .AW(AW), .WW(WW), .PW(PW)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wt_shift_i (wt_shift),
        .wt_top_i   (wt_top),
        .swap_req_i (swap_req),
        .x_valid_i  (x_valid),
        .x_i        (x_bus),
        .y_valid_o  (y_valid),
        .y_o        (y_bus)
    );

    always #4 clk = ~clk;

    // behavioural reference
    int  m_sh  [ROWS][COLS];
    int  m_act [ROWS][COLS];
    int  m_cnt;
    bit  m_pend;
    int  hw [H][ROWS][COLS];
    bit  hv [H];
    int  hx [H][ROWS];
    bit  exp_v;
    int  exp_y [COLS];
    int  cyc;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++)
                for (int c = 0; c < COLS; c++) begin
                    m_sh[r][c]  = 0;
                    m_act[r][c] = 0;
                end
            m_cnt  = 0;
            m_pend = 0;
            exp_v  = 0;
            for (int c = 0; c < COLS; c++) exp_y[c] = 0;
            cyc = 0;
        end else begin
            int  slot;
            bit  fire;
            slot = cyc % H;
            hw[slot] = m_act;
            hv[slot] = x_valid;
            for (int r = 0; r < ROWS; r++)
                hx[slot][r] = x_valid ? int'($signed(x_bus[r*AW +: AW])) : 0;
            if (cyc >= LAT - 1) begin
                int t;
                int s;
                t = cyc - (LAT - 1);
                s = t % H;
                exp_v = hv[s];
                for (int c = 0; c < COLS; c++) begin
                    int sum;
                    sum = 0;
                    for (int r = 0; r < ROWS; r++)
                        sum += hx[s][r] * hw[(t + r + c) % H][r][c];
                    exp_y[c] = sum;
                end
            end else begin
                exp_v = 0;
                for (int c = 0; c < COLS; c++) exp_y[c] = 0;
            end
            fire = (swap_req || m_pend) && (m_cnt == ROWS);
            if (fire) m_act = m_sh;
            if (wt_shift) begin
                for (int c = 0; c < COLS; c++) begin
                    for (int r = ROWS - 1; r > 0; r--) m_sh[r][c] = m_sh[r-1][c];
                    m_sh[0][c] = int'($signed(wt_top[c*WW +: WW]));
                end
            end
            if (fire) begin
                m_cnt  = wt_shift ? 1 : 0;
                m_pend = 0;
            end else begin
                if (wt_shift && m_cnt < ROWS) m_cnt++;
                if (swap_req) m_pend = 1;
            end
            cyc++;
            chk_on = 1;
        end
    end

    always @(negedge clk) begin
        if (chk_on && !done) begin
            checks++;
            if (y_valid !== exp_v) begin
                errors++;
                $display("FAIL R7 cycle %0d: y_valid=%0b expected %0b", cyc, y_valid, exp_v);
            end
            for (int c = 0; c < COLS; c++) begin
                int got;
                got = int'($signed(y_bus[c*PW +: PW]));
                checks++;
                if (got !== exp_y[c]) begin
                    errors++;
                    $display("FAIL %s cycle %0d col %0d: y=%0d expected %0d",
                             exp_v ? cur_req : "R9", cyc, c, got, exp_y[c]);
                end
            end
        end
    end

    task automatic drive(input bit sh, input bit sw, input bit xv);
        @(negedge clk);
        wt_shift = sh;
        swap_req = sw;
        x_valid  = xv;
        for (int c = 0; c < COLS; c++)
            wt_top[c*WW +: WW] = sh ? WW'($urandom_range(0, 255)) : '0;
        for (int r = 0; r < ROWS; r++)
            x_bus[r*AW +: AW] = AW'($urandom_range(0, 255));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: zero weights after reset give zero sums
        cur_req = "R1";
        for (int i = 0; i < 10; i++) drive(0, 0, 1);
        // R2: a full preload without a swap leaves results unchanged
        cur_req = "R2";
        for (int i = 0; i < ROWS; i++) drive(1, 0, 1);
        for (int i = 0; i < LAT + 2; i++) drive(0, 0, 1);
        // R4: swap with a full tile, then R6 signed sums
        cur_req = "R4";
        drive(0, 1, 0);
        for (int i = 0; i < LAT; i++) drive(0, 0, 0);
        cur_req = "R6";
        for (int i = 0; i < 12; i++) drive(0, 0, (i % 3) != 2);
        for (int i = 0; i < LAT; i++) drive(0, 0, 0);
        // R5: early request held until the tile is full
        cur_req = "R5";
        drive(1, 1, 1);
        for (int i = 0; i < ROWS - 1; i++) drive(1, 0, 1);
        for (int i = 0; i < LAT + 4; i++) drive(0, 0, 1);
        // R3: over-shift, then swap
        cur_req = "R3";
        for (int i = 0; i < ROWS + 3; i++) drive(1, 0, 0);
        drive(0, 1, 0);
        for (int i = 0; i < LAT + 4; i++) drive(0, 0, 1);
        // R4: shift on the same cycle a swap fires
        cur_req = "R4";
        for (int i = 0; i < ROWS; i++) drive(1, 0, 0);
        drive(1, 1, 1);
        for (int i = 0; i < ROWS - 1; i++) drive(1, 0, 1);
        drive(0, 1, 1);
        for (int i = 0; i < LAT + 2; i++) drive(0, 0, 1);
        // R8: vectors in flight across a swap
        cur_req = "R8";
        for (int i = 0; i < ROWS; i++) drive(1, 0, 1);
        drive(0, 1, 1);
        for (int i = 0; i < LAT + 3; i++) drive(0, 0, 1);
        // R10: streaming with concurrent preload and periodic swaps
        cur_req = "R10";
        for (int i = 0; i < 60; i++) drive(1, (i % 5) == 4, 1);
        for (int i = 0; i < 40; i++) drive((i % 2) == 0, (i % 7) == 0, (i % 4) != 3);
        // R9: idle tail
        cur_req = "R9";
        for (int i = 0; i < LAT + 6; i++) drive(0, 0, 0);
        finish_run();
    end

endmodule